// File: doc/BRIEF.md
# Clocked Serial Byte Receiver with Overrun Lockout

This block receives 8-bit frames over a clocked serial link and presents each completed byte in a receive data register for a processor to read. Serial data enters a shift register least significant bit first, one bit per rising edge of the serial clock. The serial clock is either generated by the block itself or taken from the far end. When the source is external, the clock and data pass through a synchronizer into the system clock domain.

At the end of each frame the byte moves into the data register and a full flag is set, provided the previous byte has been taken. If the full flag is still set, the new byte is dropped, an overrun flag is raised, and the receiver locks. While locked it accepts no frame, and in internal-clock mode it stops its clock. The lock holds until software has cleared both the overrun flag and the full flag. Each flag is cleared by a status read that sees it set, followed by a clear strobe. Two level interrupt requests, one for data and one for errors, follow the flags gated by a single interrupt-enable bit.

Top module: `sync_serial_rx`

## Requirements
- R1: Each frame is 8 bits, and the bit sampled first lands in `rx_data[0]` while the eighth lands in `rx_data[7]`.
- R2: With `ext_mode`=1, `sdata_in` is sampled at rising edges of `sclk_in`, after both pass through a two-stage synchronizer. A data change made two system cycles after a rising edge does not alter the sampled bit.
- R3: When a frame completes while `full_flag`=0, `rx_data` takes the byte and `full_flag` becomes 1.
- R4: `irq_data` equals `full_flag` AND `rie`.
- R5: When a frame completes while `full_flag`=1, `ovr_flag` becomes 1, while `rx_data` and `full_flag`=1 are kept.
- R6: `irq_err` equals `ovr_flag` AND `rie`.
- R7: After an overrun, no frame is accepted until both `ovr_flag` and `full_flag` are 0. Clearing only one of them leaves the receiver locked.
- R8: A flag is cleared by a one-cycle `stat_rd` pulse while the flag is 1, followed later by its clear strobe: `clr_full` for `full_flag`, `clr_ovr` for `ovr_flag`.
- R9: A clear strobe with no earlier qualifying `stat_rd` leaves its flag at 1.
- R10: While `rx_en`=0 the bit count and shift register return to empty, so a partial frame is discarded, while `rx_data` and both flags are kept.
- R11: With `ext_mode`=0, `sclk_out` is high and low for CLK_DIV system cycles each, gives exactly 8 rising edges per frame, and `sdata_in` is sampled at each of those edges.
- R12: `sclk_out` is held at 0 whenever `rx_en`=0, the receiver is locked, or `ext_mode`=1.
- R13: After reset, `rx_data`=0, both flags are 0, both interrupts are 0 and `sclk_out`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_mode | input | 1 | 1: serial clock from `sclk_in`; 0: generated on `sclk_out` |
| sclk_in | input | 1 | External serial clock |
| sdata_in | input | 1 | Serial data |
| sclk_out | output | 1 | Generated serial clock |
| rx_en | input | 1 | Receive enable |
| rie | input | 1 | Interrupt enable for both requests |
| stat_rd | input | 1 | Status read pulse; qualifies later clears of flags seen at 1 |
| clr_full | input | 1 | Clear strobe for the full flag |
| clr_ovr | input | 1 | Clear strobe for the overrun flag |
| rx_data | output | 8 | Receive data register |
| full_flag | output | 1 | Receive data register holds an unread byte |
| ovr_flag | output | 1 | A frame arrived while the register was full |
| irq_data | output | 1 | Data-received interrupt request (level) |
| irq_err | output | 1 | Error interrupt request (level) |

## Verification
The embedded properties take it as given that a clear strobe never lands in the same cycle as a frame completion. They also assume the external clock's half periods are several system cycles longer than the synchronizer delay, and that data is steady around each sampled rising edge. The stimulus keeps within these bounds in three ways. It drives the external clock with four-cycle half periods and moves data only in the low phase, apart from a deliberate late change two cycles after the rise. In internal-clock mode it changes data only after it has observed a falling edge of `sclk_out`. It issues each clear within the first few cycles of a frame, long before that frame can complete.

// File: rtl/srx_pkg.sv
package srx_pkg;
  typedef enum logic {
    SRC_INTERNAL = 1'b0,
    SRC_EXTERNAL = 1'b1
  } clk_src_e;
endpackage

// File: rtl/srx_clk_source.sv
module srx_clk_source #(
  parameter int CLK_DIV     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  srx_pkg::clk_src_e src,
  input  logic              run,
  input  logic              sclk_in,
  input  logic              sdata_in,
  output logic              sclk_out,
  output logic              sample,
  output logic              sample_bit
);
  import srx_pkg::*;

  localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

  logic [DIV_W-1:0]       div_cnt;
  logic                   sclk_q;
  logic                   div_end;
  logic [SYNC_STAGES-1:0] clk_sync;
  logic [SYNC_STAGES-1:0] dat_sync;
  logic                   ext_prev;
  logic                   int_rise;
  logic                   ext_rise;

  assign div_end = (div_cnt == DIV_W'(CLK_DIV - 1));

  // generated clock: free-running divider, parked low when not running
  always_ff @(posedge clk) begin
    if (rst || !run || src == SRC_EXTERNAL) begin
      div_cnt <= '0;
      sclk_q  <= 1'b0;
    end else if (div_end) begin
      div_cnt <= '0;
      sclk_q  <= ~sclk_q;
    end else begin
      div_cnt <= div_cnt + 1'b1;
    end
  end

  // external clock and data share one synchronizer depth
  always_ff @(posedge clk) begin
    if (rst) begin
      clk_sync <= '0;
      dat_sync <= '0;
      ext_prev <= 1'b0;
    end else begin
      clk_sync <= {clk_sync[SYNC_STAGES-2:0], sclk_in};
      dat_sync <= {dat_sync[SYNC_STAGES-2:0], sdata_in};
      ext_prev <= clk_sync[SYNC_STAGES-1];
    end
  end

  assign int_rise   = run && (src == SRC_INTERNAL) && div_end && !sclk_q;
  assign ext_rise   = run && clk_sync[SYNC_STAGES-1] && !ext_prev;
  assign sample     = (src == SRC_EXTERNAL) ? ext_rise : int_rise;
  assign sample_bit = (src == SRC_EXTERNAL) ? dat_sync[SYNC_STAGES-1] : sdata_in;
  assign sclk_out   = sclk_q;

  AST_CLK_PARKED: assert property (@(posedge clk) disable iff (rst)
    (!run || src == SRC_EXTERNAL) |=> !sclk_out); // R12
  AST_INT_SAMPLE_AT_RISE: assert property (@(posedge clk) disable iff (rst)
    (src == SRC_INTERNAL && sample) |=> sclk_out); // R11
endmodule

// File: rtl/srx_shifter.sv
module srx_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              sample,
  input  logic              sample_bit,
  output logic              frame_done,
  output logic [DATA_W-1:0] frame_byte
);
  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  logic [CNT_W-1:0]  bit_cnt;
  logic [DATA_W-1:0] shreg;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      bit_cnt    <= '0;
      shreg      <= '0;
      frame_done <= 1'b0;
    end else begin
      frame_done <= 1'b0;
      if (sample) begin
        shreg <= {sample_bit, shreg[DATA_W-1:1]};
        if (bit_cnt == CNT_W'(DATA_W - 1)) begin
          bit_cnt    <= '0;
          frame_done <= 1'b1;
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
        end
      end
    end
  end

  assign frame_byte = shreg;

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    flush |=> (bit_cnt == '0 && !frame_done)); // R10
  AST_DONE_NEEDS_SAMPLE: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> $past(sample)); // R1
endmodule

// File: rtl/srx_status.sv
module srx_status #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_done,
  input  logic [DATA_W-1:0] frame_byte,
  input  logic              stat_rd,
  input  logic              clr_full,
  input  logic              clr_ovr,
  input  logic              rie,
  output logic [DATA_W-1:0] rx_data,
  output logic              full,
  output logic              ovr,
  output logic              locked,
  output logic              irq_data,
  output logic              irq_err
);
  logic arm_full;
  logic arm_ovr;
  logic take_full_clr;
  logic take_ovr_clr;

  assign take_full_clr = clr_full && arm_full && !frame_done;
  assign take_ovr_clr  = clr_ovr && arm_ovr;

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_data  <= '0;
      full     <= 1'b0;
      ovr      <= 1'b0;
      locked   <= 1'b0;
      arm_full <= 1'b0;
      arm_ovr  <= 1'b0;
    end else begin
      if (frame_done && !full) begin
        rx_data <= frame_byte;
        full    <= 1'b1;
      end else if (take_full_clr) begin
        full <= 1'b0;
      end

      if (take_full_clr)        arm_full <= 1'b0;
      else if (stat_rd && full) arm_full <= 1'b1;

      if (frame_done && full) ovr <= 1'b1;
      else if (take_ovr_clr)  ovr <= 1'b0;

      if (take_ovr_clr)        arm_ovr <= 1'b0;
      else if (stat_rd && ovr) arm_ovr <= 1'b1;

      if (frame_done && full) locked <= 1'b1;
      else if (!full && !ovr) locked <= 1'b0;
    end
  end

  assign irq_data = full && rie;
  assign irq_err  = ovr && rie;

  AST_LOAD_WHEN_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (frame_done && !full) |=> (full && rx_data == $past(frame_byte))); // R3
  AST_OVERRUN_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (frame_done && full) |=> (full && ovr && $stable(rx_data))); // R5
  AST_LOCK_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    locked |-> !frame_done); // R7
  AST_UNARMED_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (full && !arm_full) |=> full); // R9
  AST_DATA_HELD: assert property (@(posedge clk) disable iff (rst)
    !frame_done |=> $stable(rx_data)); // R10
endmodule

// File: rtl/sync_serial_rx.sv
module sync_serial_rx #(
  parameter int DATA_W      = 8,
  parameter int CLK_DIV     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ext_mode,
  input  logic              sclk_in,
  input  logic              sdata_in,
  output logic              sclk_out,
  input  logic              rx_en,
  input  logic              rie,
  input  logic              stat_rd,
  input  logic              clr_full,
  input  logic              clr_ovr,
  output logic [DATA_W-1:0] rx_data,
  output logic              full_flag,
  output logic              ovr_flag,
  output logic              irq_data,
  output logic              irq_err
);
  import srx_pkg::*;

  logic              run;
  logic              locked;
  logic              sample;
  logic              sample_bit;
  logic              frame_done;
  logic [DATA_W-1:0] frame_byte;

  assign run = rx_en && !locked;

  srx_clk_source #(
    .CLK_DIV    (CLK_DIV),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_clk (
    .clk       (clk),
    .rst       (rst),
    .src       (clk_src_e'(ext_mode)),
    .run       (run),
    .sclk_in   (sclk_in),
    .sdata_in  (sdata_in),
    .sclk_out  (sclk_out),
    .sample    (sample),
    .sample_bit(sample_bit)
  );

  srx_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .flush     (!run),
    .sample    (sample),
    .sample_bit(sample_bit),
    .frame_done(frame_done),
    .frame_byte(frame_byte)
  );

  srx_status #(.DATA_W(DATA_W)) u_stat (
    .clk       (clk),
    .rst       (rst),
    .frame_done(frame_done),
    .frame_byte(frame_byte),
    .stat_rd   (stat_rd),
    .clr_full  (clr_full),
    .clr_ovr   (clr_ovr),
    .rie       (rie),
    .rx_data   (rx_data),
    .full      (full_flag),
    .ovr       (ovr_flag),
    .locked    (locked),
    .irq_data  (irq_data),
    .irq_err   (irq_err)
  );
endmodule

// File: tb/sync_serial_rx_test.sv
module sync_serial_rx_test;
  logic clk = 1'b0;
  logic rst, ext_mode, sclk_in, sdata_in, rx_en, rie, stat_rd, clr_full, clr_ovr;
  logic sclk_out, full_flag, ovr_flag, irq_data, irq_err;
  logic [7:0] rx_data;
  int vectors = 0;
  int errors  = 0;
  int pulses  = 0;

  always #2 clk = ~clk;

  sync_serial_rx #(.DATA_W(8), .CLK_DIV(4), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst(rst), .ext_mode(ext_mode), .sclk_in(sclk_in), .sdata_in(sdata_in),
    .sclk_out(sclk_out), .rx_en(rx_en), .rie(rie), .stat_rd(stat_rd),
    .clr_full(clr_full), .clr_ovr(clr_ovr), .rx_data(rx_data), .full_flag(full_flag),
    .ovr_flag(ovr_flag), .irq_data(irq_data), .irq_err(irq_err)
  );

  always @(posedge sclk_out) pulses++;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic clear(input logic f, input logic o);
    stat_rd = 1'b1;
    @(negedge clk);
    stat_rd  = 1'b0;
    clr_full = f;
    clr_ovr  = o;
    @(negedge clk);
    clr_full = 1'b0;
    clr_ovr  = 1'b0;
  endtask

  // late = 1 flips the data two cycles after each rising edge
  task automatic ext_frame(input logic [7:0] b, input logic late);
    for (int i = 0; i < 8; i++) begin
      sdata_in = b[i];
      sclk_in  = 1'b0;
      repeat (4) @(negedge clk);
      sclk_in = 1'b1;
      repeat (2) @(negedge clk);
      if (late) sdata_in = ~b[i];
      repeat (2) @(negedge clk);
    end
    sclk_in = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic wait_fall();
    logic p;
    p = sclk_out;
    @(negedge clk);
    while (!(p && !sclk_out)) begin
      p = sclk_out;
      @(negedge clk);
    end
  endtask

  task automatic int_frame(input logic [7:0] b, input logic cf, input logic co);
    sdata_in = b[0];
    if (cf || co) clear(cf, co);
    for (int i = 1; i < 8; i++) begin
      wait_fall();
      sdata_in = b[i];
    end
    wait_fall();
  endtask

  initial begin
    #600000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    int p0;
    logic [7:0] v;
    rst = 1'b1; ext_mode = 1'b1; sclk_in = 1'b0; sdata_in = 1'b0; rx_en = 1'b0;
    rie = 1'b0; stat_rd = 1'b0; clr_full = 1'b0; clr_ovr = 1'b0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R13 rx_data", rx_data, 0);
    chk("R13 full", full_flag, 0);
    chk("R13 ovr", ovr_flag, 0);
    chk("R13 irq", {irq_data, irq_err}, 0);
    chk("R13 sclk_out", sclk_out, 0);

    // exhaustive byte sweep, external clock
    rx_en = 1'b1;
    for (int k = 0; k < 256; k++) begin
      rie = k[0];
      ext_frame(8'(k), k[1]);
      chk("R1 R2 R3 byte", rx_data, k);
      chk("R3 full", full_flag, 1);
      chk("R4 irq_data", irq_data, k[0]);
      chk("R12 sclk_out parked ext", sclk_out, 0);
      clear(1'b1, 1'b0);
      chk("R8 full cleared", full_flag, 0);
    end

    // unqualified clear
    rie = 1'b1;
    ext_frame(8'h3C, 1'b0);
    clr_full = 1'b1;
    @(negedge clk);
    clr_full = 1'b0;
    @(negedge clk);
    chk("R9 full kept", full_flag, 1);

    // overrun and lockout
    ext_frame(8'hA5, 1'b0);
    chk("R5 ovr", ovr_flag, 1);
    chk("R5 full", full_flag, 1);
    chk("R5 data kept", rx_data, 8'h3C);
    chk("R6 irq_err", irq_err, 1);
    rie = 1'b0;
    @(negedge clk);
    chk("R6 irq_err masked", irq_err, 0);
    chk("R4 irq_data masked", irq_data, 0);
    rie = 1'b1;
    ext_frame(8'h5A, 1'b0);
    chk("R7 locked data", rx_data, 8'h3C);
    chk("R7 locked ovr", ovr_flag, 1);
    clear(1'b0, 1'b1);
    chk("R8 ovr cleared", ovr_flag, 0);
    ext_frame(8'h11, 1'b0);
    chk("R7 still locked data", rx_data, 8'h3C);
    chk("R7 still locked ovr", ovr_flag, 0);
    clear(1'b1, 1'b0);
    chk("R8 full cleared after lock", full_flag, 0);
    ext_frame(8'h22, 1'b0);
    chk("R7 released data", rx_data, 8'h22);
    chk("R7 released ovr", ovr_flag, 0);
    clear(1'b1, 1'b0);

    // abort a partial frame
    ext_frame(8'h77, 1'b0);
    for (int i = 0; i < 4; i++) begin
      sdata_in = 1'b1;
      sclk_in  = 1'b0;
      repeat (4) @(negedge clk);
      sclk_in = 1'b1;
      repeat (4) @(negedge clk);
    end
    sclk_in = 1'b0;
    rx_en   = 1'b0;
    repeat (5) @(negedge clk);
    chk("R10 data kept", rx_data, 8'h77);
    chk("R10 full kept", full_flag, 1);
    rx_en = 1'b1;
    clear(1'b1, 1'b0);
    ext_frame(8'hC3, 1'b0);
    chk("R10 partial discarded", rx_data, 8'hC3);
    clear(1'b1, 1'b0);

    // internal clock sweep
    rx_en    = 1'b0;
    ext_mode = 1'b0;
    @(negedge clk);
    rx_en = 1'b1;
    for (int k = 0; k < 64; k++) begin
      v  = 8'((k * 37 + 5) % 256);
      p0 = pulses;
      int_frame(v, k != 0, 1'b0);
      chk("R11 byte", rx_data, v);
      chk("R11 full", full_flag, 1);
      chk("R11 eight pulses", pulses - p0, 8);
    end

    // internal overrun stops the clock
    int_frame(8'h99, 1'b1, 1'b0);
    chk("R11 byte before overrun", rx_data, 8'h99);
    int_frame(8'h66, 1'b0, 1'b0);
    chk("R5 internal ovr", ovr_flag, 1);
    chk("R5 internal data kept", rx_data, 8'h99);
    p0 = pulses;
    repeat (100) @(negedge clk);
    chk("R12 no pulses while locked", pulses - p0, 0);
    chk("R12 sclk_out low while locked", sclk_out, 0);
    p0 = pulses;
    int_frame(8'h0F, 1'b1, 1'b1);
    chk("R7 resumed byte", rx_data, 8'h0F);
    chk("R11 resumed pulses", pulses - p0, 8);
    rx_en = 1'b0;
    p0 = pulses;
    repeat (40) @(negedge clk);
    chk("R12 disabled no pulses", pulses - p0, 0);
    chk("R12 disabled sclk_out", sclk_out, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule